// File: doc/BRIEF.md
# Float to Signed Integer Converter

This block turns an IEEE-754 single-precision value into a 32-bit two's-complement integer. The rounding direction is picked per operand by a 3-bit mode input. Values that cannot be represented are clamped to the signed limits and flagged, and are never wrapped or truncated. A flag also reports when fraction bits were discarded. The block sits in the execution path of a floating-point unit. The caller keeps any exception state and any mode register.

The operand passes through two register stages. The first stage unpacks the fields, restores the hidden leading one, and shifts the 24-bit significand so that its binary point lines up with the integer LSB. It keeps one round bit and one sticky bit. This stage also classifies infinities, NaNs, out-of-range exponents and unsupported modes. The second stage applies the rounding increment, negates the result, and makes the final range check. One operand is accepted every cycle. Each operand's mode travels with it through the pipe.

Top module: `f2i_convert`

## Requirements
- R1: in_valid asserted at a clock edge gives out_valid high after the second following edge, so the result appears two cycles later. Back-to-back operands come out on consecutive cycles in order. out_valid is low during and after reset until data arrives.
- R2: A finite input whose value is an integer in [-2^31, 2^31-1] returns exactly that integer, with both flags clear.
- R3: Mode 3'b000 (nearest, ties to even) rounds to the closer integer and breaks exact halfway ties toward the even integer. For example, 0.5 gives 0, 2.5 gives 2 and 3.5 gives 4.
- R4: Mode 3'b001 (toward zero) drops the fraction, so 2.5 gives 2 and -1.75 gives -1.
- R5: Mode 3'b010 (toward minus infinity) rounds down, so -2.5 gives -3 and 2.5 gives 2.
- R6: Mode 3'b011 (toward plus infinity) rounds up, so 2.5 gives 3 and 1.25 gives 2.
- R7: Mode 3'b100 (nearest, ties away from zero) rounds halfway cases away from zero, so 0.5 gives 1 and -2.5 gives -3.
- R8: Modes 3'b101, 3'b110 and 3'b111 return 0 with invalid set and inexact clear, whatever the operand.
- R9: A positive value of 2^31 or more, +infinity, or a NaN of either sign returns 32'h7FFFFFFF with invalid set.
- R10: A negative value below -2^31, or -infinity, returns 32'h80000000 with invalid set. Exactly -2^31 returns 32'h80000000 with invalid clear.
- R11: Zeros and subnormals of either sign, and tiny values such as ±2^-64, return 0 under nearest rounding. The directed modes move such a value to +1 (plus infinity, positive input) or -1 (minus infinity, negative input).
- R12: inexact is set exactly when nonzero fraction bits were discarded and the result is in range. invalid and inexact are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_value | input | 32 | Single-precision operand (sign bit 31, exponent 30:23, fraction 22:0) |
| in_mode | input | 3 | Rounding mode for this operand |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_result | output | 32 | Signed integer result |
| out_invalid | output | 1 | Invalid-operation flag for this result |
| out_inexact | output | 1 | Inexact flag for this result |

## Verification
Operands enter one per cycle. As a result, the alignment of one operand and the rounding of the one before it happen in the same cycle, and each may use a different mode. The bench streams back-to-back operands with alternating modes, and some of them are out-of-range. Each result is then compared in its own output cycle with the value its own mode demands. A mode or class that leaks from one stage to the other gives a wrong integer or a wrong flag.

// File: rtl/f2i_pkg.sv
// Package: shared widths, mode codes and stage types for the float to
// signed integer converter. Assumes IEEE-754 single precision input.
package f2i_pkg;
    localparam int FP_W   = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int INT_W  = 32;
    localparam int RM_W   = 3;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int SH_W   = EXP_W + 1;

    localparam logic [RM_W-1:0] RM_NEAR_EVEN = 3'b000;
    localparam logic [RM_W-1:0] RM_ZERO      = 3'b001;
    localparam logic [RM_W-1:0] RM_DOWN      = 3'b010;
    localparam logic [RM_W-1:0] RM_UP        = 3'b011;
    localparam logic [RM_W-1:0] RM_NEAR_AWAY = 3'b100;

    // Operand class decided during alignment
    typedef enum logic [1:0] {
        K_NUM     = 2'd0,
        K_SAT_POS = 2'd1,
        K_SAT_NEG = 2'd2,
        K_BAD_RM  = 2'd3
    } kind_e;

    typedef struct packed {
        logic              sign;
        logic [INT_W-1:0]  mag;
        logic              rnd;
        logic              stk;
        logic [RM_W-1:0]   rm;
        kind_e             kind;
    } aligned_t;

    typedef struct packed {
        logic [INT_W-1:0]  value;
        logic              invalid;
        logic              inexact;
    } result_t;
endpackage

// File: rtl/f2i_align.sv
// Module: unpacks the operand, classifies specials and shifts the 24-bit
// significand to integer alignment, producing a round and a sticky bit.
// Assumes: purely combinational; exponents at or above 2^31 saturate here.
module f2i_align
    import f2i_pkg::*;
(
    input  logic [FP_W-1:0] op,
    input  logic [RM_W-1:0] rm,
    output aligned_t        al
);
    localparam int EXT_W   = 2 * SIG_W + 1;
    localparam logic [SH_W-1:0] LSB_E   = SH_W'(BIAS + FRAC_W);
    localparam logic [SH_W-1:0] TOP_E   = SH_W'(BIAS + INT_W - 1);
    localparam logic [SH_W-1:0] MAX_RSH = SH_W'(SIG_W + 1);

    logic                 sign;
    logic [EXP_W-1:0]     ex;
    logic [FRAC_W-1:0]    fr;
    logic [SIG_W-1:0]     sig;
    logic [SH_W-1:0]      ex_eff;
    logic [SH_W-1:0]      rsh;
    logic [SH_W-1:0]      lsh;
    logic [EXT_W-1:0]     ext_sh;

    // Field split, effective exponent and shift amounts
    always_comb begin
        sign   = op[FP_W-1];
        ex     = op[FP_W-2 -: EXP_W];
        fr     = op[FRAC_W-1:0];
        sig    = {|ex, fr};
        ex_eff = (ex == '0) ? SH_W'(1) : {1'b0, ex};
        rsh    = LSB_E - ex_eff;
        lsh    = ex_eff - LSB_E;
        ext_sh = {sig, {(SIG_W + 1){1'b0}}} >> rsh;
    end

    // Classification and aligned magnitude selection
    always_comb begin
        al      = '0;
        al.sign = sign;
        al.rm   = rm;
        al.kind = K_NUM;
        if (rm > RM_NEAR_AWAY) begin
            al.kind = K_BAD_RM;
        end else if (ex == '1) begin
            al.kind = (fr != '0 || !sign) ? K_SAT_POS : K_SAT_NEG;
        end else if (ex_eff > TOP_E) begin
            al.kind = sign ? K_SAT_NEG : K_SAT_POS;
        end else if (ex_eff == TOP_E) begin
            if (sign && fr == '0)
                al.mag = {1'b1, {(INT_W - 1){1'b0}}};
            else
                al.kind = sign ? K_SAT_NEG : K_SAT_POS;
        end else if (ex_eff >= LSB_E) begin
            al.mag = INT_W'(sig) << lsh;
        end else if (rsh > MAX_RSH) begin
            al.stk = |sig;
        end else begin
            al.mag = INT_W'(ext_sh[EXT_W-1 -: SIG_W]);
            al.rnd = ext_sh[SIG_W];
            al.stk = |ext_sh[SIG_W-1:0];
        end
    end
endmodule

// File: rtl/f2i_round.sv
// Module: applies the mode-dependent increment, negates, range checks and
// forms the flags. Assumes the magnitude is already integer aligned.
module f2i_round
    import f2i_pkg::*;
(
    input  aligned_t al,
    output result_t  res
);
    localparam logic [INT_W-1:0] INT_MAX = {1'b0, {(INT_W - 1){1'b1}}};
    localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W - 1){1'b0}}};

    logic             lost;
    logic             inc;
    logic [INT_W:0]   sum;
    logic [INT_W:0]   lim;

    // Rounding increment per mode
    always_comb begin
        lost = al.rnd | al.stk;
        case (al.rm)
            RM_NEAR_EVEN: inc = al.rnd & (al.stk | al.mag[0]);
            RM_ZERO:      inc = 1'b0;
            RM_DOWN:      inc = al.sign & lost;
            RM_UP:        inc = ~al.sign & lost;
            RM_NEAR_AWAY: inc = al.rnd;
            default:      inc = 1'b0;
        endcase
        sum = {1'b0, al.mag} + (INT_W + 1)'(inc);
        lim = al.sign ? {1'b0, INT_MIN} : {1'b0, INT_MAX};
    end

    // Result and flag selection by operand class
    always_comb begin
        res = '0;
        case (al.kind)
            K_BAD_RM:  res.invalid = 1'b1;
            K_SAT_POS: begin res.value = INT_MAX; res.invalid = 1'b1; end
            K_SAT_NEG: begin res.value = INT_MIN; res.invalid = 1'b1; end
            default: begin
                if (sum > lim) begin
                    res.value   = al.sign ? INT_MIN : INT_MAX;
                    res.invalid = 1'b1;
                end else begin
                    res.value   = al.sign ? -sum[INT_W-1:0] : sum[INT_W-1:0];
                    res.inexact = lost;
                end
            end
        endcase
    end
endmodule

// File: rtl/f2i_stage.sv
// Module: one pipeline register with a valid bit.
// Assumes synchronous active-low reset clears both valid and data.
module f2i_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vin,
    input  logic [W-1:0] din,
    output logic         vout,
    output logic [W-1:0] dout
);
    // Capture data and strobe every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vout <= 1'b0;
            dout <= '0;
        end else begin
            vout <= vin;
            dout <= din;
        end
    end
endmodule

// File: rtl/f2i_convert.sv
// Module: top of the float to signed integer converter. Two stages,
// alignment then rounding, one operand per cycle, fixed latency of two.
// Assumes the caller holds the mode register and accumulates the flags.
module f2i_convert
    import f2i_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FP_W-1:0]   in_value,
    input  logic [RM_W-1:0]   in_mode,
    output logic              out_valid,
    output logic [INT_W-1:0]  out_result,
    output logic              out_invalid,
    output logic              out_inexact
);
    localparam int AL_W  = $bits(aligned_t);
    localparam int RES_W = $bits(result_t);

    aligned_t al_c, al_q;
    result_t  res_c, res_q;
    logic     v_mid;

    f2i_align u_align (.op(in_value), .rm(in_mode), .al(al_c));

    f2i_stage #(.W(AL_W)) u_stage_al (
        .clk(clk), .rst_n(rst_n), .vin(in_valid), .din(al_c),
        .vout(v_mid), .dout(al_q)
    );

    f2i_round u_round (.al(al_q), .res(res_c));

    f2i_stage #(.W(RES_W)) u_stage_res (
        .clk(clk), .rst_n(rst_n), .vin(v_mid), .din(res_c),
        .vout(out_valid), .dout(res_q)
    );

    // Output field breakout
    always_comb begin
        out_result  = res_q.value;
        out_invalid = res_q.invalid;
        out_inexact = res_q.inexact;
    end
endmodule

// File: rtl/f2i_convert_chk.sv
// Module: port-level properties of the converter, bound to the top.
module f2i_convert_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_value,
    input logic [2:0]  in_mode,
    input logic        out_valid,
    input logic [31:0] out_result,
    input logic        out_invalid,
    input logic        out_inexact
);
    logic is_nan, is_zero, good_rm, neg_over;

    // Operand predicates used by the properties
    always_comb begin
        is_nan   = (in_value[30:23] == 8'hFF) && (in_value[22:0] != '0);
        is_zero  = (in_value[30:0] == '0);
        good_rm  = (in_mode <= 3'b100);
        neg_over = in_value[31] && (in_value[30:23] > 8'd158);
    end

    a_r1_latency_on: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);
    a_r1_latency_off: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);
    a_r8_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !good_rm) |-> ##2 (out_invalid && !out_inexact && out_result == 32'h0));
    a_r9_nan_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && good_rm && is_nan) |-> ##2 (out_invalid && out_result == 32'h7FFF_FFFF));
    a_r10_neg_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && good_rm && neg_over && !is_nan) |-> ##2 (out_invalid && out_result == 32'h8000_0000));
    a_r11_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && good_rm && is_zero) |-> ##2 (out_result == 32'h0 && !out_invalid && !out_inexact));
    a_r12_flags_apart: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_invalid && out_inexact));
endmodule

bind f2i_convert f2i_convert_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
    .in_mode(in_mode), .out_valid(out_valid), .out_result(out_result),
    .out_invalid(out_invalid), .out_inexact(out_inexact)
);

// File: tb/f2i_convert_test.sv
// Directed bench for the float to signed integer converter.
module f2i_convert_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_value = '0;
    logic [2:0]  in_mode = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_invalid;
    logic        out_inexact;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [2:0] RNE = 3'b000, RTZ = 3'b001, RDN = 3'b010,
                           RUP = 3'b011, RMM = 3'b100;

    f2i_convert uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
        .in_mode(in_mode), .out_valid(out_valid), .out_result(out_result),
        .out_invalid(out_invalid), .out_inexact(out_inexact)
    );

    always #5 clk = ~clk;

    // Compare valid, result and flags against expectation
    task automatic check(input string tag, input logic [31:0] er,
                         input logic ei, input logic ex);
        n_total++;
        if (!(out_valid === 1'b1 && out_result === er &&
              out_invalid === ei && out_inexact === ex)) begin
            n_fail++;
            $display("FAIL %s: got v=%b res=%h inv=%b inx=%b, expected v=1 res=%h inv=%b inx=%b",
                     tag, out_valid, out_result, out_invalid, out_inexact, er, ei, ex);
        end
    endtask

    // Single conversion: drive one cycle, sample after the second edge
    task automatic conv(input logic [31:0] v, input logic [2:0] m,
                        input logic [31:0] er, input logic ei, input logic ex,
                        input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_value = v; in_mode = m;
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); #2;
        check(tag, er, ei, ex);
    endtask

    task automatic t_reset;
        n_total++;
        if (out_valid !== 1'b0 || out_result !== 32'h0) begin
            n_fail++;
            $display("FAIL R1 reset: got v=%b res=%h, expected v=0 res=00000000",
                     out_valid, out_result);
        end
    endtask

    task automatic t_exact;
        conv(32'h42C8_0000, RNE, 32'd100,        0, 0, "R2 100.0");
        conv(32'hC0E0_0000, RUP, 32'hFFFF_FFF9,  0, 0, "R2 -7.0");
        conv(32'h4E80_0000, RTZ, 32'h4000_0000,  0, 0, "R2 2^30");
        conv(32'h4EFF_FFFF, RDN, 32'h7FFF_FF80,  0, 0, "R2 largest below 2^31");
    endtask

    task automatic t_near_even;
        conv(32'h3F00_0000, RNE, 32'd0, 0, 1, "R3 0.5");
        conv(32'h4020_0000, RNE, 32'd2, 0, 1, "R3 2.5");
        conv(32'h4060_0000, RNE, 32'd4, 0, 1, "R3 3.5");
        conv(32'h3F40_0000, RNE, 32'd1, 0, 1, "R3 0.75");
        conv(32'hC020_0000, RNE, 32'hFFFF_FFFE, 0, 1, "R3 -2.5");
        conv(32'hBFE0_0000, RNE, 32'hFFFF_FFFE, 0, 1, "R3 -1.75");
    endtask

    task automatic t_zero_mode;
        conv(32'h4020_0000, RTZ, 32'd2,         0, 1, "R4 2.5");
        conv(32'hBFE0_0000, RTZ, 32'hFFFF_FFFF, 0, 1, "R4 -1.75");
    endtask

    task automatic t_down;
        conv(32'hC020_0000, RDN, 32'hFFFF_FFFD, 0, 1, "R5 -2.5");
        conv(32'h4020_0000, RDN, 32'd2,         0, 1, "R5 2.5");
    endtask

    task automatic t_up;
        conv(32'h4020_0000, RUP, 32'd3,         0, 1, "R6 2.5");
        conv(32'h3FA0_0000, RUP, 32'd2,         0, 1, "R6 1.25");
        conv(32'hC020_0000, RUP, 32'hFFFF_FFFE, 0, 1, "R6 -2.5");
    endtask

    task automatic t_away;
        conv(32'h3F00_0000, RMM, 32'd1,         0, 1, "R7 0.5");
        conv(32'hC020_0000, RMM, 32'hFFFF_FFFD, 0, 1, "R7 -2.5");
        conv(32'h3FA0_0000, RMM, 32'd1,         0, 1, "R7 1.25");
    endtask

    task automatic t_reserved;
        conv(32'h4020_0000, 3'b101, 32'd0, 1, 0, "R8 mode 5");
        conv(32'h7FC0_0000, 3'b111, 32'd0, 1, 0, "R8 mode 7 NaN");
        conv(32'hCF80_0000, 3'b110, 32'd0, 1, 0, "R8 mode 6 big");
    endtask

    task automatic t_pos_sat;
        conv(32'h4F00_0000, RNE, 32'h7FFF_FFFF, 1, 0, "R9 2^31");
        conv(32'h7F80_0000, RTZ, 32'h7FFF_FFFF, 1, 0, "R9 +inf");
        conv(32'h7FC0_0000, RNE, 32'h7FFF_FFFF, 1, 0, "R9 NaN");
        conv(32'hFFC0_0000, RDN, 32'h7FFF_FFFF, 1, 0, "R9 negative NaN");
    endtask

    task automatic t_neg_sat;
        conv(32'hCF80_0000, RNE, 32'h8000_0000, 1, 0, "R10 -2^32");
        conv(32'hFF80_0000, RUP, 32'h8000_0000, 1, 0, "R10 -inf");
        conv(32'hCF00_0000, RNE, 32'h8000_0000, 0, 0, "R10 exactly -2^31");
        conv(32'hCF00_0001, RTZ, 32'h8000_0000, 1, 0, "R10 just below -2^31");
    endtask

    task automatic t_tiny;
        conv(32'h1F80_0000, RNE, 32'd0,         0, 1, "R11 +2^-64");
        conv(32'h9F80_0000, RNE, 32'd0,         0, 1, "R11 -2^-64");
        conv(32'h1F80_0000, RUP, 32'd1,         0, 1, "R11 +2^-64 up");
        conv(32'h9F80_0000, RDN, 32'hFFFF_FFFF, 0, 1, "R11 -2^-64 down");
        conv(32'h0000_0000, RNE, 32'd0,         0, 0, "R11 +0");
        conv(32'h8000_0000, RDN, 32'd0,         0, 0, "R11 -0");
        conv(32'h0000_0001, RNE, 32'd0,         0, 1, "R11 subnormal");
        conv(32'h0000_0001, RUP, 32'd1,         0, 1, "R11 subnormal up");
        conv(32'h8000_0001, RDN, 32'hFFFF_FFFF, 0, 1, "R11 neg subnormal down");
    endtask

    task automatic t_inexact;
        conv(32'h4000_0000, RUP, 32'd2,         0, 0, "R12 exact 2.0 no inexact");
        conv(32'h4B80_0001, RTZ, 32'h0100_0002, 0, 0, "R12 large exact");
        conv(32'h3F7F_FFFF, RTZ, 32'd0,         0, 1, "R12 just below 1");
    endtask

    // Back-to-back operands, alternating modes, results on consecutive cycles
    task automatic t_stream;
        @(negedge clk);
        in_valid = 1'b1; in_value = 32'h4020_0000; in_mode = RUP;
        @(negedge clk);
        in_value = 32'h4020_0000; in_mode = RNE;
        @(posedge clk); #2;
        check("R1 stream first (2.5 up)", 32'd3, 0, 1);
        @(negedge clk);
        in_value = 32'h4F00_0000; in_mode = RTZ;
        @(posedge clk); #2;
        check("R1 stream second (2.5 even)", 32'd2, 0, 1);
        @(negedge clk);
        in_value = 32'hC020_0000; in_mode = RMM;
        @(posedge clk); #2;
        check("R1 stream third (2^31 sat)", 32'h7FFF_FFFF, 1, 0);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); #2;
        check("R1 stream fourth (-2.5 away)", 32'hFFFF_FFFD, 0, 1);
        @(posedge clk); #2;
        n_total++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 stream drain: got v=%b, expected v=0", out_valid);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        t_reset();
        t_exact();
        t_near_even();
        t_zero_mode();
        t_down();
        t_up();
        t_away();
        t_reserved();
        t_pos_sat();
        t_neg_sat();
        t_tiny();
        t_inexact();
        t_stream();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_total++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule